// File: doc/BRIEF.md
# Address-Latched Extended RAM Bank Selector

This block sits on a CPU bus and controls a bank-switched RAM expansion. A fixed 4 KB window at `$C000`–`$CFFF` shows one bank of the expansion RAM at a time. The host picks the bank by writing to the control page `$FFxx`. The bank number comes from the low byte of the write address, not from the data bus. For this reason the block has no data input at all.

A write to `$FFC0 + n` makes bank `n` visible. Any other write into the control page turns the window off. The number of usable banks depends on how many 64 KB boards are installed, which is set by a parameter. While the window is on, a bus access inside it asserts the RAM chip select at a physical address made of the bank number and the 12-bit window offset. A write strobe accompanies the chip select on write cycles.

Top module: `xram_bank_sel`

## Requirements
- R1: After a synchronous active-low reset, `win_en` is 0 and no access asserts `ram_cs`.
- R2: The number of usable banks is 4 + 16 × (NUM_BOARDS − 1): 4 for one board, 20 for two and 36 for three (the default).
- R3: A write (`rw_n` = 0) to address `$FF00 + lo`, where n = lo − `$C0` lies in 0 to 35 and n is below the bank count, sets the bank register to n and `win_en` to 1. The write is taken on the falling edge of `bus_phase`, and the new state is not visible while the write's `bus_phase` is still high.
- R4: A write to the `$FFxx` page whose low byte gives no usable bank sets `win_en` to 0. This covers a low byte below `$C0`, above `$E3`, or with n at or above the bank count.
- R5: Reads of any address, including the control page, and writes outside the `$FFxx` page leave `win_en` and the bank register unchanged.
- R6: While `win_en` = 1, an access with `addr[15:12]` = `4'hC` and `bus_phase` = 1 asserts `ram_cs`. In that case `ram_addr` = {bank[5:0], addr[11:0]}. Whenever `ram_cs` is 0, `ram_addr` is 0.
- R7: `ram_we` is 1 exactly when `ram_cs` is 1 and `rw_n` is 0.
- R8: `ram_cs` is never asserted for addresses outside `$C000`–`$CFFF`, and never asserted while `win_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; faster than the bus phase |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase | input | 1 | Bus data phase; high while an access is valid |
| addr | input | 16 | CPU address |
| rw_n | input | 1 | 1 = read, 0 = write |
| win_en | output | 1 | Extended RAM window enabled |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 18 | Physical RAM address {bank, offset} |

## Verification
The assertions assume three things about the bus. `addr` and `rw_n` stay stable from before `bus_phase` rises until one clock after it falls. Each phase lasts at least one clock. `rst_n` is driven low at time zero. The bench's bus task holds the address and direction for a whole three-clock bus cycle and only changes them while `bus_phase` is low. It drives reset low from the first instant. A one-board and a three-board instance share the same stimulus, so both bank counts are swept over all 256 control-page low bytes.

// File: rtl/xram_pkg.sv
// Package: shared constants for the extended RAM bank selector.
// Assumes a 16-bit CPU address bus and 4 KB banks.
package xram_pkg;
    localparam int ADDR_W     = 16;
    localparam int OFF_W      = 12;          // 4 KB window offset
    localparam int MAX_BOARDS = 3;
    localparam int BANK_W     = 6;           // holds bank numbers up to 63
    localparam int PA_W       = BANK_W + OFF_W;
    localparam logic [7:0] CTL_PAGE  = 8'hFF;
    localparam logic [7:0] SEL_BASE  = 8'hC0;
    localparam logic [7:0] SEL_SPAN  = 8'd36;
    localparam logic [3:0] WIN_NIB   = 4'hC;

    // Usable banks for a given number of installed boards.
    function automatic int banks_for(input int boards);
        return (boards < 1) ? 0 : 4 + 16 * (boards - 1);
    endfunction
endpackage

// File: rtl/xram_ctl_decode.sv
// Control-page decoder: flags accesses to the control page and turns the
// low address byte into a bank number plus a "usable bank" flag.
// Assumes BANK_COUNT never exceeds the 36-address select span.
module xram_ctl_decode
    import xram_pkg::*;
#(
    parameter int BANK_COUNT = 36
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ctl,
    output logic              sel_ok,
    output logic [BANK_W-1:0] sel_num
);
    localparam logic [7:0] COUNT8 = 8'(BANK_COUNT);

    logic [7:0] lo;
    logic [7:0] off;

    // Purpose: decode page, select offset and bank-count limit.
    always_comb begin
        lo      = addr[7:0];
        off     = lo - SEL_BASE;
        is_ctl  = (addr[ADDR_W-1:8] == CTL_PAGE);
        sel_ok  = (lo >= SEL_BASE) && (off < SEL_SPAN) && (off < COUNT8);
        sel_num = off[BANK_W-1:0];
    end
endmodule

// File: rtl/xram_bank_reg.sv
// Bank register: on the falling edge of bus_phase, a control-page write
// either loads a usable bank and enables the window, or disables it.
// Assumes addr/rw_n are stable through the clock that sees the fall.
module xram_bank_reg
    import xram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase,
    input  logic              rw_n,
    input  logic              is_ctl,
    input  logic              sel_ok,
    input  logic [BANK_W-1:0] sel_num,
    output logic              en,
    output logic [BANK_W-1:0] bank
);
    logic phase_q;
    logic ctl_wr;

    // Purpose: remember last bus phase to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= bus_phase;
    end

    // Purpose: qualify a control write at the end of its data phase.
    always_comb ctl_wr = phase_q && !bus_phase && !rw_n && is_ctl;

    // Purpose: latch the bank number or drop the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            bank <= '0;
        end else if (ctl_wr) begin
            en <= sel_ok;
            if (sel_ok) bank <= sel_num;
        end
    end
endmodule

// File: rtl/xram_win_map.sv
// Window mapper: claims $C000-$CFFF while the window is enabled and builds
// the physical RAM address and strobes. Assumes bus_phase marks valid cycles.
module xram_win_map
    import xram_pkg::*;
(
    input  logic              en,
    input  logic [BANK_W-1:0] bank,
    input  logic              bus_phase,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [PA_W-1:0]   ram_addr
);
    // Purpose: window hit, strobes and masked physical address.
    always_comb begin
        ram_cs   = en && bus_phase && (addr[ADDR_W-1:OFF_W] == WIN_NIB);
        ram_we   = ram_cs && !rw_n;
        ram_addr = ram_cs ? {bank, addr[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/xram_bank_sel.sv
// Top: address-latched extended RAM bank selector. NUM_BOARDS (1..3)
// sets the usable bank count. Assumes a clk faster than the bus phase.
module xram_bank_sel
    import xram_pkg::*;
#(
    parameter int NUM_BOARDS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase,
    input  logic [15:0]       addr,
    input  logic              rw_n,
    output logic              win_en,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [17:0]       ram_addr
);
    localparam int BANK_COUNT = banks_for(NUM_BOARDS);

    logic              is_ctl;
    logic              sel_ok;
    logic [BANK_W-1:0] sel_num;
    logic [BANK_W-1:0] bank;

    xram_ctl_decode #(.BANK_COUNT(BANK_COUNT)) u_dec (
        .addr    (addr),
        .is_ctl  (is_ctl),
        .sel_ok  (sel_ok),
        .sel_num (sel_num)
    );

    xram_bank_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_phase (bus_phase),
        .rw_n      (rw_n),
        .is_ctl    (is_ctl),
        .sel_ok    (sel_ok),
        .sel_num   (sel_num),
        .en        (win_en),
        .bank      (bank)
    );

    xram_win_map u_map (
        .en        (win_en),
        .bank      (bank),
        .bus_phase (bus_phase),
        .rw_n      (rw_n),
        .addr      (addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr)
    );
endmodule

// File: rtl/xram_bank_sel_chk.sv
// Checker for xram_bank_sel, attached by bind. Assumes addr/rw_n stable
// around each falling edge of bus_phase and rst_n low at time zero.
module xram_bank_sel_chk
    import xram_pkg::*;
#(
    parameter int NUM_BOARDS = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_phase,
    input logic [15:0] addr,
    input logic        rw_n,
    input logic        win_en,
    input logic        ram_cs,
    input logic        ram_we,
    input logic [17:0] ram_addr
);
    localparam int BANK_COUNT = banks_for(NUM_BOARDS);

    a_r1_reset_off: assert property (@(posedge clk) !rst_n |=> !win_en);

    a_r8_cs_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (win_en && bus_phase && addr[15:12] == 4'hC));

    a_r7_we_is_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && !rw_n));

    a_r2_bank_below_count: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> (int'(ram_addr[17:12]) < BANK_COUNT));

    a_r3_rise_from_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_en) |-> ($past(!bus_phase && !rw_n && addr[15:8] == 8'hFF)
                           && $past(bus_phase, 2)));

    a_r5_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_phase && $past(bus_phase) && rw_n) |=> $stable(win_en));

    a_r6_addr_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs |-> (ram_addr == '0));
endmodule

bind xram_bank_sel xram_bank_sel_chk #(.NUM_BOARDS(NUM_BOARDS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_phase (bus_phase),
    .addr      (addr),
    .rw_n      (rw_n),
    .win_en    (win_en),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr)
);

// File: tb/tb_xram_bank_sel.sv
// Bench: sweeps every control-page low byte on a three-board and a
// one-board instance, probing the window after each write.
module tb_xram_bank_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_phase = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rw_n = 1'b1;
    logic        en3, cs3, we3, en1, cs1, we1;
    logic [17:0] pa3, pa1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    logic       m_en3 = 1'b0, m_en1 = 1'b0;
    logic [5:0] m_bk3 = '0, m_bk1 = '0;

    // samples taken during the high bus phase
    logic       s_en3, s_cs3, s_we3, s_en1, s_cs1, s_we1;
    logic [17:0] s_pa3, s_pa1;

    always #5 clk = ~clk;

    xram_bank_sel #(.NUM_BOARDS(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .addr(addr), .rw_n(rw_n),
        .win_en(en3), .ram_cs(cs3), .ram_we(we3), .ram_addr(pa3));

    xram_bank_sel #(.NUM_BOARDS(1)) dut_one (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .addr(addr), .rw_n(rw_n),
        .win_en(en1), .ram_cs(cs1), .ram_we(we1), .ram_addr(pa1));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: setup, high phase (sample), falling edge, settle.
    task automatic bus(input logic [15:0] a, input logic rwn);
        @(negedge clk);
        addr = a; rw_n = rwn; bus_phase = 1'b0;
        @(negedge clk);
        bus_phase = 1'b1;
        @(negedge clk);
        s_en3 = en3; s_cs3 = cs3; s_we3 = we3; s_pa3 = pa3;
        s_en1 = en1; s_cs1 = cs1; s_we1 = we1; s_pa1 = pa1;
        bus_phase = 1'b0;
        @(negedge clk);
    endtask

    // Reference update for a write into the control page.
    task automatic model_ctl(input logic [7:0] lo);
        int n;
        n = int'(lo) - 192;
        if (n >= 0 && n < 36) begin m_en3 = 1'b1; m_bk3 = 6'(n); end else m_en3 = 1'b0;
        if (n >= 0 && n < 4)  begin m_en1 = 1'b1; m_bk1 = 6'(n); end else m_en1 = 1'b0;
    endtask

    // Access the window and compare strobes and physical address.
    task automatic probe(input logic [11:0] off, input logic rwn, input string req);
        logic [17:0] e3, e1;
        bus({4'hC, off}, rwn);
        e3 = m_en3 ? {m_bk3, off} : 18'h0;
        e1 = m_en1 ? {m_bk1, off} : 18'h0;
        chk(s_cs3 == m_en3, {req, " cs 3-board"}, s_cs3, m_en3);
        chk(s_pa3 == e3, {req, " addr 3-board"}, s_pa3, e3);
        chk(s_we3 == (m_en3 && !rwn), "R7 we 3-board", s_we3, m_en3 && !rwn);
        chk(s_cs1 == m_en1, {req, " cs 1-board"}, s_cs1, m_en1);
        chk(s_pa1 == e1, {req, " addr 1-board"}, s_pa1, e1);
        chk(s_we1 == (m_en1 && !rwn), "R7 we 1-board", s_we1, m_en1 && !rwn);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(en3 == 1'b0, "R1 reset win_en 3-board", en3, 0);
        chk(en1 == 1'b0, "R1 reset win_en 1-board", en1, 0);
        rst_n = 1'b1;
        probe(12'h123, 1'b1, "R1 R8 after reset");

        for (int lo = 0; lo < 256; lo++) begin
            logic p3, p1;
            p3 = m_en3; p1 = m_en1;
            bus({8'hFF, 8'(lo)}, 1'b0);
            // R3: the write must not take effect before the falling edge
            chk(s_en3 == p3, "R3 no early update 3-board", s_en3, p3);
            chk(s_en1 == p1, "R3 no early update 1-board", s_en1, p1);
            model_ctl(8'(lo));
            chk(en3 == m_en3, "R3 R4 win_en 3-board", en3, m_en3);
            chk(en1 == m_en1, "R2 R3 R4 win_en 1-board", en1, m_en1);
            probe(12'((lo * 37) & 12'hFFF), 1'b1, "R6 read");
            probe(12'((lo * 91 + 5) & 12'hFFF), 1'b0, "R6 write");
            if (lo % 16 == 3) begin
                bus(16'hFFC5, 1'b1);          // R5 control-page read
                chk(en3 == m_en3, "R5 ctl read 3-board", en3, m_en3);
                bus({8'hFE, 8'(lo)}, 1'b0);   // R5 write outside page
                chk(en3 == m_en3, "R5 off-page write 3-board", en3, m_en3);
                probe(12'hABC, 1'b1, "R5 bank kept");
            end
        end

        bus(16'hFFE3, 1'b0); model_ctl(8'hE3);
        chk(en3 == 1'b1, "R3 top bank 35 enable", en3, 1);
        chk(en1 == 1'b0, "R2 bank 35 on one board", en1, 0);
        bus(16'hFFC1, 1'b1);
        bus(16'hCFC1, 1'b0);
        probe(12'hFFF, 1'b1, "R5 bank 35 kept");
        bus(16'hD000, 1'b1);
        chk(s_cs3 == 1'b0, "R8 no cs above window", s_cs3, 0);
        bus(16'hBFFF, 1'b0);
        chk(s_cs3 == 1'b0 && s_we3 == 1'b0, "R8 no cs below window", s_cs3, 0);
        bus(16'hFFC2, 1'b0); model_ctl(8'hC2);
        probe(12'h000, 1'b0, "R3 bank 2");
        bus(16'hFFE4, 1'b0); model_ctl(8'hE4);
        chk(en3 == 1'b0, "R4 past span disables", en3, 0);
        probe(12'h456, 1'b1, "R8 disabled");

        done = 1'b1;
        summary();
    end
endmodule